// File: doc/BRIEF.md
# Matrix Keypad Scanner with Snapshot FIFO

This block scans a 16-row by 8-column key matrix. It drives one row low at a time and samples the columns through a two-flop synchroniser. A row is accepted only if its columns hold steady through a programmable debounce window. Each complete sweep of the matrix gives one snapshot of up to eight packed key entries. A snapshot that holds at least one key is pushed into a small FIFO.

Software reads the head snapshot through two 32-bit words. Reading the upper word pops the snapshot. The interrupt register shows a live entry count. A sticky threshold status bit, gated by an enable bit, drives a level interrupt. Per-row mask words keep chosen keys out of the snapshots altogether, so a masked key can never raise an interrupt.

Scanning runs from the slow scan clock. The register port runs on the same clock. A sweep starts with a 5-cycle lead. Each row then takes 16 settle cycles plus the debounce count. While keys stay held, a programmable gap separates consecutive sweeps.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, the control word and the interrupt word read 0, `irq` is low and `row_n` is all ones.
- R2: While enabled, exactly one `row_n` bit is low at a time, and rows are visited 0,1,...,15 and then back to 0. While disabled, `row_n` is all ones.
- R3: Each entry is 8 bits: bit 7 valid, bits 6:3 row, bits 2:0 column. Entries are ordered by ascending row, then by ascending column. At most eight entries are kept. Entry k sits in byte k%4 of word 0x10 for k<4 and of word 0x14 for k≥4. Unused bytes read 0.
- R4: Mask word 0x38+4*row, bit c = 1, drops key (row,c) from every snapshot.
- R5: A row whose synchronised columns change during its debounce window (debounce ≥ 1) contributes no entries to that sweep.
- R6: Word 0x0C reads 5 + 16*(16 + debounce), the cycle length of one sweep.
- R7: A sweep with no key pushes nothing. Bits 7:4 of word 0x04 hold the FIFO count. A read of 0x14 pops one snapshot. Reading the key words of an empty FIFO returns 0 and leaves the count at 0.
- R8: When the FIFO is full, new snapshots are dropped and the count stays at the depth (4).
- R9: Status bit 2 of 0x04 is set when a push brings the count to at least the threshold, provided the threshold is nonzero. It stays set until software writes 1 to bit 2.
- R10: `irq` is high exactly while the status bit and the interrupt enable (control bit 3) are both set.
- R11: The control word has enable in bit 0, interrupt enable in bit 3, debounce in bits 13:4 and threshold in bits 17:14. All of these read back as written.
- R12: Word 0x08 holds a 16-bit gap, in cycles, inserted between sweeps while keys are held. It reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on 0x14) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| row_n | output | 16 | Row drive, active low |
| col_n | input | 8 | Column sense, low when a key on the driven row is closed |
| irq | output | 1 | Level interrupt |

## Verification
The hardest condition to reach is a row that settles and is then rejected by the debounce check. The column must change after the capture point but before the row window closes. The bench models this with a chattering key that flips its contact on every clock, while a steady key sits on a different row. With a nonzero debounce count, the snapshot must then hold only the steady key. The full-FIFO drop is reached by holding keys with a zero gap across six sweeps before draining.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int ROWS   = 16;
  localparam int COLS   = 8;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int SLOTS  = 8;
  localparam int ENT_W  = 1 + ROW_W + COL_W;
  localparam int SNAP_W = SLOTS * ENT_W;
  localparam int NUM_W  = $clog2(SLOTS + 1);
  localparam int DEB_W  = 10;
  localparam int THR_W  = 4;
  localparam int RPT_W  = 16;
  localparam int TICK_W = 16;
  localparam int IDLY_W = 20;
  localparam int SETTLE = 16;
  localparam int LEAD   = 5;

  typedef enum logic [2:0] {S_OFF, S_LEAD, S_ROW, S_DONE, S_GAP} scan_state_e;

  function automatic logic [ENT_W-1:0] make_entry(input logic [ROW_W-1:0] r,
                                                  input logic [COL_W-1:0] c);
    return {1'b1, r, c};
  endfunction

  function automatic logic [TICK_W-1:0] row_last_tick(input logic [DEB_W-1:0] deb);
    return TICK_W'(SETTLE - 1) + TICK_W'(deb);
  endfunction

  function automatic logic [IDLY_W-1:0] sweep_cycles(input logic [DEB_W-1:0] deb);
    return IDLY_W'(LEAD) + IDLY_W'(ROWS) * (IDLY_W'(SETTLE) + IDLY_W'(deb));
  endfunction
endpackage

// File: rtl/kps_scan_seq.sv
module kps_scan_seq
  import kps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DEB_W-1:0]  deb,
  input  logic [RPT_W-1:0]  rpt,
  input  logic [COLS-1:0]   col_n,
  input  logic              key_held,
  output logic [ROWS-1:0]   row_n,
  output logic              sweep_start,
  output logic              row_done,
  output logic [ROW_W-1:0]  row_idx,
  output logic [COLS-1:0]   row_hits,
  output logic              sweep_done
);
  scan_state_e       state_q;
  logic [TICK_W-1:0] tick_q;
  logic [ROW_W-1:0]  row_q;
  logic [COLS-1:0]   sync1_q, sync2_q, cap_q;
  logic              bad_q;
  logic              at_cap, row_end;
  logic [COLS-1:0]   cur_cap;
  logic              cur_bad;

  always_comb begin
    at_cap  = (state_q == S_ROW) && (tick_q == TICK_W'(SETTLE - 1));
    cur_cap = at_cap ? sync2_q : cap_q;
    cur_bad = bad_q | ((state_q == S_ROW) && (tick_q > TICK_W'(SETTLE - 1)) &&
                       (sync2_q != cap_q));
    row_end = (state_q == S_ROW) && (tick_q == row_last_tick(deb));
  end

  assign row_done    = row_end;
  assign row_idx     = row_q;
  assign row_hits    = cur_bad ? '0 : ~cur_cap;
  assign sweep_done  = (state_q == S_DONE);
  assign sweep_start = (state_q == S_LEAD) && (tick_q == '0);
  assign row_n       = (state_q == S_ROW) ? ~(ROWS'(1) << row_q) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= col_n;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      tick_q  <= '0;
      row_q   <= '0;
      cap_q   <= '1;
      bad_q   <= 1'b0;
    end else if (!enable) begin
      state_q <= S_OFF;
      tick_q  <= '0;
      row_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      case (state_q)
        S_OFF: begin
          state_q <= S_LEAD;
          tick_q  <= '0;
        end
        S_LEAD: begin
          if (tick_q == TICK_W'(LEAD - 1)) begin
            state_q <= S_ROW;
            tick_q  <= '0;
            row_q   <= '0;
            bad_q   <= 1'b0;
          end else tick_q <= tick_q + 1'b1;
        end
        S_ROW: begin
          cap_q <= cur_cap;
          bad_q <= cur_bad;
          if (row_end) begin
            tick_q <= '0;
            bad_q  <= 1'b0;
            if (row_q == ROW_W'(ROWS - 1)) state_q <= S_DONE;
            else row_q <= row_q + 1'b1;
          end else tick_q <= tick_q + 1'b1;
        end
        S_DONE: begin
          tick_q  <= '0;
          state_q <= (key_held && rpt != '0) ? S_GAP : S_LEAD;
        end
        S_GAP: begin
          if (tick_q == TICK_W'(rpt) - 1'b1) begin
            state_q <= S_LEAD;
            tick_q  <= '0;
          end else tick_q <= tick_q + 1'b1;
        end
        default: state_q <= S_OFF;
      endcase
    end
  end

  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_n) <= 1);
  // R2
  off_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (row_n == '1));
endmodule

// File: rtl/kps_collect.sv
module kps_collect
  import kps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              clear,
  input  logic              row_done,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COLS-1:0]   row_hits,
  input  logic [COLS-1:0]   row_mask,
  input  logic              sweep_done,
  output logic              key_held,
  output logic              push,
  output logic [SNAP_W-1:0] push_data
);
  logic [SLOTS-1:0][ENT_W-1:0] snap_q, snap_d;
  logic [NUM_W-1:0]            num_q, num_d;

  always_comb begin
    snap_d = snap_q;
    num_d  = num_q;
    if (!enable || clear) begin
      snap_d = '0;
      num_d  = '0;
    end else if (row_done) begin
      for (int c = 0; c < COLS; c++) begin
        if (row_hits[c] && !row_mask[c] && num_d < NUM_W'(SLOTS)) begin
          snap_d[num_d[NUM_W-2:0]] = make_entry(row_idx, COL_W'(c));
          num_d = num_d + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      num_q  <= '0;
    end else begin
      snap_q <= snap_d;
      num_q  <= num_d;
    end
  end

  assign key_held  = (num_q != '0);
  assign push      = sweep_done && key_held;
  assign push_data = snap_q;

  // R7
  push_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> push_data[ENT_W-1]);
  // R3
  slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    num_q <= NUM_W'(SLOTS));
endmodule

// File: rtl/kps_fifo.sv
module kps_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             push_ok
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count != CNT_W'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign dout    = (count != '0) ? mem_q[rd_q] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_q] <= din;
        wr_q        <= bump(wr_q);
      end
      if (pop_ok) rd_q <= bump(rd_q);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && push && !pop) |=> $stable(count));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push) |=> (count == '0));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [15:0] row_n,
  input  logic [7:0]  col_n,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [7:0] A_CTL = 8'h00, A_INT = 8'h04, A_GAP = 8'h08,
                         A_DLY = 8'h0C, A_LO  = 8'h10, A_HI  = 8'h14,
                         A_MSK = 8'h38;

  logic               en_q, ie_q, stat_q;
  logic [DEB_W-1:0]   deb_q;
  logic [THR_W-1:0]   thr_q;
  logic [RPT_W-1:0]   rpt_q;
  logic [COLS-1:0]    mask_q [ROWS];

  logic               sweep_start, row_done, sweep_done, key_held, push, push_ok, pop;
  logic [ROW_W-1:0]   row_idx;
  logic [COLS-1:0]    row_hits;
  logic [SNAP_W-1:0]  push_data, head;
  logic [CNT_W-1:0]   count;
  logic [CNT_W:0]     count_next;
  logic               stat_set, stat_clr, wr_mask;
  logic [7:0]         moff;
  logic [ROW_W-1:0]   midx;

  kps_scan_seq u_seq (
    .clk, .rst_n, .enable(en_q), .deb(deb_q), .rpt(rpt_q), .col_n,
    .key_held, .row_n, .sweep_start, .row_done, .row_idx, .row_hits, .sweep_done
  );

  kps_collect u_col (
    .clk, .rst_n, .enable(en_q), .clear(sweep_start), .row_done, .row_idx,
    .row_hits, .row_mask(mask_q[row_idx]), .sweep_done, .key_held, .push, .push_data
  );

  kps_fifo #(.DEPTH(FIFO_DEPTH), .W(SNAP_W)) u_fifo (
    .clk, .rst_n, .push, .din(push_data), .pop, .dout(head), .count, .push_ok
  );

  assign pop        = bus_rd && (bus_addr == A_HI);
  assign count_next = (CNT_W+1)'(count) + (CNT_W+1)'(push_ok) -
                      (CNT_W+1)'(pop && count != '0);
  assign stat_set   = push_ok && (thr_q != '0) && (count_next >= (CNT_W+1)'(thr_q));
  assign stat_clr   = bus_wr && (bus_addr == A_INT) && bus_wdata[2];
  assign moff       = bus_addr - A_MSK;
  assign midx       = moff[ROW_W+1:2];
  assign wr_mask    = bus_wr && (bus_addr >= A_MSK) && (moff < 8'(ROWS * 4)) &&
                      (bus_addr[1:0] == 2'b00);
  assign irq        = stat_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      deb_q  <= '0;
      thr_q  <= '0;
      rpt_q  <= '0;
      stat_q <= 1'b0;
      for (int r = 0; r < ROWS; r++) mask_q[r] <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTL) begin
        en_q  <= bus_wdata[0];
        ie_q  <= bus_wdata[3];
        deb_q <= bus_wdata[4 +: DEB_W];
        thr_q <= bus_wdata[14 +: THR_W];
      end
      if (bus_wr && bus_addr == A_GAP) rpt_q <= bus_wdata[RPT_W-1:0];
      if (wr_mask) mask_q[midx] <= bus_wdata[COLS-1:0];
      if (stat_set)      stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTL: bus_rdata = {14'b0, thr_q, deb_q, ie_q, 2'b0, en_q};
        A_INT: bus_rdata = {24'b0, 4'(count), 1'b0, stat_q, 2'b0};
        A_GAP: bus_rdata = 32'(rpt_q);
        A_DLY: bus_rdata = 32'(sweep_cycles(deb_q));
        A_LO:  bus_rdata = head[31:0];
        A_HI:  bus_rdata = head[63:32];
        default: if (bus_addr >= A_MSK && moff < 8'(ROWS * 4) && bus_addr[1:0] == 2'b00)
                   bus_rdata = 32'(mask_q[midx]);
      endcase
    end
  end

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !stat_set) |=> !stat_q);
  // R9
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q);
endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] row_n;
  logic [7:0]  col_n;
  logic        irq;

  logic [7:0]  keys [16];
  logic [7:0]  mask_m [16];
  logic        bounce_on = 1'b0, bphase = 1'b0;
  int          b_row = 0, b_col = 0;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) bphase <= ~bphase;

  keypad_scanner i_keypad_scanner (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .row_n, .col_n, .irq
  );

  always_comb begin
    col_n = '1;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (!row_n[r] && keys[r][c]) col_n[c] = 1'b0;
    if (bounce_on && !row_n[b_row] && bphase) col_n[b_col] = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FIFO-check FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit en, bit ie, int deb, int thr);
    return (32'(thr) << 14) | (32'(deb) << 4) | (32'(ie) << 3) | 32'(en);
  endfunction

  function automatic logic [63:0] exp_snap();
    logic [63:0] s = '0;
    int n = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (keys[r][c] && !mask_m[r][c] && n < 8) begin
          s[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return s;
  endfunction

  task automatic get_count(output int n);
    logic [31:0] d;
    rd(8'h04, d);
    n = int'(d[7:4]);
  endtask

  task automatic cleanup();
    logic [31:0] d;
    int n;
    wr(8'h00, 32'h0);
    for (int i = 0; i < 8; i++) begin
      get_count(n);
      if (n != 0) rd(8'h14, d);
    end
    wr(8'h04, 32'h7);
  endtask

  task automatic run_pattern(input string tag, input int deb);
    logic [63:0] e;
    logic [31:0] lo, hi;
    int n;
    e = exp_snap();
    wr(8'h00, ctl(1, 1, deb, 1));
    if (e == '0) begin
      repeat (3 * (5 + 16 * (16 + deb)) + 20) @(negedge clk);
      wr(8'h00, 32'h0);
      get_count(n);
      chk(n == 0, {tag, " empty sweep pushes nothing"}, 64'(n), 64'd0);
    end else begin
      for (int i = 0; i < 4000 && !irq; i++) @(negedge clk);
      chk(irq == 1'b1, {tag, " irq on snapshot"}, 64'(irq), 64'd1);
      wr(8'h00, 32'h0);
      rd(8'h10, lo);
      rd(8'h14, hi);
      chk({hi, lo} == e, {tag, " snapshot"}, {hi, lo}, e);
    end
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("watchdog FAIL timeout actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, prev, seen_bad;
    int unsigned sd;
    logic [15:0] seen;
    logic [63:0] e;
    logic [31:0] lo, hi;
    for (int r = 0; r < 16; r++) begin keys[r] = '0; mask_m[r] = '0; end
    sd = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1 control reset", 64'(d), 0);
    rd(8'h04, d); chk(d == 0, "R1 int reset", 64'(d), 0);
    chk(irq == 0, "R1 irq reset", 64'(irq), 0);
    chk(row_n == 16'hFFFF, "R1 rows idle", 64'(row_n), 64'hFFFF);

    // R11 readback, R12 gap readback
    wr(8'h00, ctl(0, 1, 'h155, 3));
    rd(8'h00, d); chk(d == ctl(0, 1, 'h155, 3), "R11 control fields", 64'(d), 64'(ctl(0, 1, 'h155, 3)));
    // R6 sweep length
    rd(8'h0C, d); chk(d == 5 + 16 * (16 + 'h155), "R6 delay deb 0x155", 64'(d), 64'(5 + 16 * (16 + 'h155)));
    wr(8'h00, 32'h0);
    rd(8'h0C, d); chk(d == 261, "R6 delay deb 0", 64'(d), 64'd261);
    wr(8'h08, 32'h0000_BEEF);
    rd(8'h08, d); chk(d == 32'hBEEF, "R12 gap readback", 64'(d), 64'hBEEF);
    wr(8'h08, 32'h0);

    // R2 row sweep order
    wr(8'h00, ctl(1, 0, 0, 0));
    seen = '0; prev = -1; seen_bad = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if ($countones(~row_n) > 1) seen_bad++;
      for (int r = 0; r < 16; r++)
        if (!row_n[r]) begin
          seen[r] = 1'b1;
          if (prev >= 0 && r != prev && r != (prev + 1) % 16) seen_bad++;
          prev = r;
        end
    end
    chk(seen_bad == 0 && seen == 16'hFFFF, "R2 one row, ascending", 64'(seen), 64'hFFFF);
    wr(8'h00, 32'h0);
    @(negedge clk);
    chk(row_n == 16'hFFFF, "R2 disabled rows high", 64'(row_n), 64'hFFFF);

    // R3 directed patterns
    keys[0][0] = 1; run_pattern("R3 corner r0c0", 0); keys[0][0] = 0;
    keys[15][7] = 1; run_pattern("R3 corner r15c7", 0); keys[15][7] = 0;
    keys[1] = 8'hFF; keys[7] = 8'h05; run_pattern("R3 ten keys capped at eight", 0);
    keys[1] = 0; keys[7] = 0;

    // R3 random patterns
    for (int it = 0; it < 8; it++) begin
      int k;
      k = $urandom_range(1, 10);
      for (int j = 0; j < k; j++) keys[$urandom_range(0, 15)][$urandom_range(0, 7)] = 1'b1;
      run_pattern("R3 random", $urandom_range(0, 3));
      for (int r = 0; r < 16; r++) keys[r] = '0;
    end

    // R4 mask
    wr(8'h38 + 8'd12, 32'h0F); mask_m[3] = 8'h0F;
    rd(8'h44, d); chk(d == 32'h0F, "R4 mask readback", 64'(d), 64'h0F);
    keys[3][2] = 1; keys[3][5] = 1; keys[4][1] = 1;
    run_pattern("R4 masked row", 0);
    keys[3] = 0; keys[4] = 0;
    keys[3][1] = 1;
    run_pattern("R4 only masked key", 0);
    keys[3] = 0;
    wr(8'h44, 32'h0); mask_m[3] = 0;

    // R5 debounce rejects chattering row
    b_row = 2; b_col = 1; bounce_on = 1'b1;
    keys[9][6] = 1;
    run_pattern("R5 chatter row dropped", 4);
    keys[9][6] = 0; bounce_on = 1'b0;

    // R7 empty sweep
    run_pattern("R7 no keys", 0);

    // R9 / R10 threshold
    keys[5][3] = 1;
    wr(8'h00, ctl(1, 1, 0, 2));
    n = 0;
    for (int i = 0; i < 2000 && n < 1; i++) get_count(n);
    rd(8'h04, d);
    chk(d[2] == 0 && irq == 0, "R9 below threshold", 64'(d), 64'h10);
    for (int i = 0; i < 2000 && n < 2; i++) get_count(n);
    rd(8'h04, d);
    chk(d[2] == 1 && irq == 1, "R9 R10 threshold reached", 64'({irq, d}), 64'h1_0000_0024);
    wr(8'h00, ctl(0, 0, 0, 2));
    @(negedge clk);
    rd(8'h04, d);
    chk(irq == 0 && d[2] == 1, "R10 gated by enable bit", 64'({irq, d[2]}), 64'h1);
    wr(8'h04, 32'h4);
    rd(8'h04, d);
    chk(d[2] == 0, "R9 write-one clears", 64'(d[2]), 0);
    cleanup();

    // R8 overflow, R7 pops
    wr(8'h00, ctl(1, 0, 0, 1));
    repeat (6 * 261 + 50) @(negedge clk);
    wr(8'h00, 32'h0);
    get_count(n);
    chk(n == 4, "R8 count saturates", 64'(n), 64'd4);
    e = exp_snap();
    rd(8'h10, lo); rd(8'h14, hi);
    chk({hi, lo} == e, "R8 retained snapshot", {hi, lo}, e);
    get_count(n);
    chk(n == 3, "R7 pop decrements", 64'(n), 64'd3);
    cleanup();
    keys[5] = 0;
    rd(8'h14, d);
    chk(d == 0, "R7 empty read zero", 64'(d), 0);
    get_count(n);
    chk(n == 0, "R7 empty pop keeps zero", 64'(n), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule